// File: doc/BRIEF.md
# In-DRAM Bulk Row Copy Sequencer

This block lives inside a memory controller. It takes one request for a bulk row copy or a bulk row clear and turns it into an ordered stream of DRAM commands. The data moves inside the memory device and never crosses the memory channel. A request names a source row and a destination row. Each row is given as a bank, a subarray and a row index. The unit of work is one whole row.

There are two ways to do the work. When both rows sit behind one row buffer (same bank and same subarray), the block uses the fast path. It closes the bank, opens the source row so the whole row lands in the buffer, then opens the destination row at once so the buffered data is written into it, and closes the bank again.

When the rows sit behind different row buffers, the block uses the streaming path. It closes both banks and opens both rows. It then issues one internal transfer per cache-line-sized column, one column per cycle, so that consecutive transfers overlap. Finally it closes both banks.

A clear request is a fast-path copy from a reserved all-zero row in the destination's subarray. Three programmable gaps set the spacing between commands. The requester sees a busy level and a one-cycle completion pulse.

Top module: `bulk_row_copier`

## Requirements
- R1: After reset, `busy`, `done` and `cmd_valid` are all 0 until a request is accepted.
- R2: When the effective source and the destination share bank and subarray but differ in row, the commands are PRE(bank), ACT(source row), ACT(destination row), PRE(bank). The `cmd_op` encoding is 0 none, 1 ACT, 2 PRE, 3 XFER. For PRE, `cmd_sub` and `cmd_row` are 0. `cmd_peer_bank` and `cmd_col` are 0 on every command except XFER.
- R3: In the fast path, the destination ACT comes exactly G(cfg_act_act) cycles after the source ACT, and the final PRE comes G(cfg_act_act) cycles after the destination ACT, where G(x) = x when x > 0 and 1 when x = 0.
- R4: When bank or subarray differs, the commands are PRE(source bank), PRE(destination bank) one cycle later, ACT(source row) one cycle later, then ACT(destination row) G(cfg_act_act) cycles after the source ACT.
- R5: In the streaming path, the first XFER comes G(cfg_act_xfer) cycles after the destination ACT. One XFER follows on each consecutive cycle for columns 0 to COLS-1. Each XFER carries `cmd_bank` = source bank and `cmd_peer_bank` = destination bank.
- R6: In the streaming path, PRE(source bank) comes G(cfg_xfer_pre) cycles after the last XFER, and PRE(destination bank) comes one cycle after that.
- R7: A clear request (`req_zero` = 1) ignores the source fields. It copies from row ZERO_ROW (default 0) of the destination bank and subarray, using the fast path.
- R8: When the effective source equals the destination, no command is issued, `busy` stays 0, and `done` pulses in the first cycle after acceptance.
- R9: The first command is issued in the first cycle after acceptance. `busy` is 1 from that cycle through the cycle of the final PRE, and `done` is 1 for exactly the following cycle.
- R10: `req_valid` while the block is not idle is ignored: the command stream in progress is unchanged and no second operation starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; taken only when idle |
| req_zero | input | 1 | 1 = clear the destination row, 0 = copy |
| req_src_bank | input | BANK_W | Source bank |
| req_src_sub | input | SUB_W | Source subarray |
| req_src_row | input | ROW_W | Source row within subarray |
| req_dst_bank | input | BANK_W | Destination bank |
| req_dst_sub | input | SUB_W | Destination subarray |
| req_dst_row | input | ROW_W | Destination row within subarray |
| cfg_act_act | input | GAP_W | Minimum gap after an ACT before the next ACT or fast-path PRE |
| cfg_act_xfer | input | GAP_W | Minimum gap from destination ACT to the first XFER |
| cfg_xfer_pre | input | GAP_W | Minimum gap from the last XFER to the PRE |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_op | output | 2 | Command code (see R2) |
| cmd_bank | output | BANK_W | Target bank (source bank for XFER) |
| cmd_sub | output | SUB_W | Subarray for ACT |
| cmd_row | output | ROW_W | Row for ACT |
| cmd_peer_bank | output | BANK_W | Destination bank for XFER |
| cmd_col | output | COL_W | Column for XFER |

## Verification
Every result is due at a cycle that follows from the gap formula. The cycle is counted from the acceptance edge, and the first sample after that edge is cycle 1.

Due cycles for the fast path:
- PRE at cycle 1.
- Source ACT at cycle 2.
- Destination ACT at cycle 2+G(aa).
- Final PRE at cycle 2+2G(aa).

Due cycles for the streaming path:
- The two PREs at cycles 1 and 2.
- Source ACT at cycle 3.
- Destination ACT at cycle 3+G(aa).
- XFER for column c at cycle 3+G(aa)+G(ax)+c.
- The closing PREs at cycles L+G(xp) and L+G(xp)+1, where L is the cycle of the last XFER.

`done` is due one cycle after the last command. The bench builds this timetable arithmetically for each request. It samples on the falling edge of every cycle, and each cycle it compares the presence and fields of a command, `busy` and `done` against the timetable. A missing, early, late or extra command therefore shows up as a mismatch in the exact cycle where it happens.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_ACT  = 2'd1,
    OP_PRE  = 2'd2,
    OP_XFER = 2'd3
  } cmd_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE_A,
    ST_PRE_B,
    ST_ACT_S,
    ST_ACT_D,
    ST_XFER,
    ST_PRE_E,
    ST_PRE_F,
    ST_DONE
  } seq_state_e;

endpackage

// File: rtl/rcp_route.sv
module rcp_route #(
  parameter int BANK_W   = 2,
  parameter int SUB_W    = 2,
  parameter int ROW_W    = 4,
  parameter int ZERO_ROW = 0
) (
  input  logic              zero,
  input  logic [BANK_W-1:0] src_bank,
  input  logic [SUB_W-1:0]  src_sub,
  input  logic [ROW_W-1:0]  src_row,
  input  logic [BANK_W-1:0] dst_bank,
  input  logic [SUB_W-1:0]  dst_sub,
  input  logic [ROW_W-1:0]  dst_row,
  output logic [BANK_W-1:0] eff_bank,
  output logic [SUB_W-1:0]  eff_sub,
  output logic [ROW_W-1:0]  eff_row,
  output logic              streaming,
  output logic              trivial
);

  // A clear is a copy from the reserved zero row beside the destination (R7)
  always_comb begin
    if (zero) begin
      eff_bank = dst_bank;
      eff_sub  = dst_sub;
      eff_row  = ROW_W'(ZERO_ROW);
    end else begin
      eff_bank = src_bank;
      eff_sub  = src_sub;
      eff_row  = src_row;
    end
  end

  // Shared row buffer means same bank and same subarray
  assign streaming = (eff_bank != dst_bank) || (eff_sub != dst_sub);
  assign trivial   = !streaming && (eff_row == dst_row);

  always_comb begin
    a_r7_zero_is_fast : assert (!(zero && streaming));
  end

endmodule

// File: rtl/rcp_gap_timer.sv
module rcp_gap_timer #(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] gap,
  output logic             ready
);

  logic [GAP_W-1:0] cnt_q;

  // Cycles to hold after a command: a gap of 0 acts as 1
  function automatic logic [GAP_W-1:0] hold_cycles(input logic [GAP_W-1:0] g);
    return (g == '0) ? '0 : g - GAP_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= hold_cycles(gap);
    else if (cnt_q != '0)   cnt_q <= cnt_q - GAP_W'(1);
  end

  assign ready = (cnt_q == '0);

  a_r3_gap_holds : assert property (@(posedge clk) disable iff (!rst_n)
    load && (gap > GAP_W'(1)) |=> !ready);

  a_r3_gap_unit : assert property (@(posedge clk) disable iff (!rst_n)
    load && (gap <= GAP_W'(1)) |=> ready);

endmodule

// File: rtl/rcp_col_ctr.sv
module rcp_col_ctr #(
  parameter int COLS  = 8,
  parameter int COL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [COL_W-1:0] col,
  output logic             last
);

  logic [COL_W-1:0] col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      col_q <= '0;
    else if (clear)  col_q <= '0;
    else if (step)   col_q <= last ? '0 : col_q + COL_W'(1);
  end

  assign col  = col_q;
  assign last = (col_q == COL_W'(COLS - 1));

  a_r5_col_in_range : assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= COL_W'(COLS - 1));

endmodule

// File: rtl/bulk_row_copier.sv
module bulk_row_copier
  import rcp_pkg::*;
#(
  parameter int BANK_W   = 2,
  parameter int SUB_W    = 2,
  parameter int ROW_W    = 4,
  parameter int COLS     = 8,
  parameter int GAP_W    = 4,
  parameter int ZERO_ROW = 0,
  localparam int COL_W   = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_zero,
  input  logic [BANK_W-1:0] req_src_bank,
  input  logic [SUB_W-1:0]  req_src_sub,
  input  logic [ROW_W-1:0]  req_src_row,
  input  logic [BANK_W-1:0] req_dst_bank,
  input  logic [SUB_W-1:0]  req_dst_sub,
  input  logic [ROW_W-1:0]  req_dst_row,
  input  logic [GAP_W-1:0]  cfg_act_act,
  input  logic [GAP_W-1:0]  cfg_act_xfer,
  input  logic [GAP_W-1:0]  cfg_xfer_pre,
  output logic              busy,
  output logic              done,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [SUB_W-1:0]  cmd_sub,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [BANK_W-1:0] cmd_peer_bank,
  output logic [COL_W-1:0]  cmd_col
);

  // Routing of the incoming request
  logic [BANK_W-1:0] rt_bank;
  logic [SUB_W-1:0]  rt_sub;
  logic [ROW_W-1:0]  rt_row;
  logic              rt_streaming;
  logic              rt_trivial;

  rcp_route #(
    .BANK_W(BANK_W), .SUB_W(SUB_W), .ROW_W(ROW_W), .ZERO_ROW(ZERO_ROW)
  ) u_route (
    .zero      (req_zero),
    .src_bank  (req_src_bank),
    .src_sub   (req_src_sub),
    .src_row   (req_src_row),
    .dst_bank  (req_dst_bank),
    .dst_sub   (req_dst_sub),
    .dst_row   (req_dst_row),
    .eff_bank  (rt_bank),
    .eff_sub   (rt_sub),
    .eff_row   (rt_row),
    .streaming (rt_streaming),
    .trivial   (rt_trivial)
  );

  // Sequencer state and latched operands
  seq_state_e        state_q, state_d;
  logic [BANK_W-1:0] sb_q, db_q;
  logic [SUB_W-1:0]  ss_q, ds_q;
  logic [ROW_W-1:0]  sr_q, dr_q;
  logic              streaming_q;

  // Named internal events
  logic              accept;
  logic              cmd_state;
  logic              gap_ready;
  logic              issue;
  logic              xfer_step;
  logic [GAP_W-1:0]  gap_val;
  logic [COL_W-1:0]  col;
  logic              col_last;

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign cmd_state = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign issue     = cmd_state && gap_ready;
  assign xfer_step = issue && (state_q == ST_XFER);

  rcp_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (issue),
    .gap   (gap_val),
    .ready (gap_ready)
  );

  rcp_col_ctr #(.COLS(COLS), .COL_W(COL_W)) u_col (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .step  (xfer_step),
    .col   (col),
    .last  (col_last)
  );

  // Next state and gap to hold after the command issued in this state
  always_comb begin
    state_d = state_q;
    gap_val = GAP_W'(1);
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_d = rt_trivial ? ST_DONE : ST_PRE_A;
      ST_PRE_A: if (issue) state_d = streaming_q ? ST_PRE_B : ST_ACT_S;
      ST_PRE_B: if (issue) state_d = ST_ACT_S;
      ST_ACT_S: begin
        gap_val = cfg_act_act;
        if (issue) state_d = ST_ACT_D;
      end
      ST_ACT_D: begin
        gap_val = streaming_q ? cfg_act_xfer : cfg_act_act;
        if (issue) state_d = streaming_q ? ST_XFER : ST_PRE_E;
      end
      ST_XFER: begin
        gap_val = col_last ? cfg_xfer_pre : GAP_W'(1);
        if (issue && col_last) state_d = ST_PRE_E;
      end
      ST_PRE_E: if (issue) state_d = streaming_q ? ST_PRE_F : ST_DONE;
      ST_PRE_F: if (issue) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      sb_q        <= '0;
      ss_q        <= '0;
      sr_q        <= '0;
      db_q        <= '0;
      ds_q        <= '0;
      dr_q        <= '0;
      streaming_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        sb_q        <= rt_bank;
        ss_q        <= rt_sub;
        sr_q        <= rt_row;
        db_q        <= req_dst_bank;
        ds_q        <= req_dst_sub;
        dr_q        <= req_dst_row;
        streaming_q <= rt_streaming;
      end
    end
  end

  // Command decode
  cmd_op_e op_sel;

  always_comb begin
    op_sel        = OP_NOP;
    cmd_bank      = '0;
    cmd_sub       = '0;
    cmd_row       = '0;
    cmd_peer_bank = '0;
    cmd_col       = '0;
    if (issue) begin
      unique case (state_q)
        ST_PRE_A, ST_PRE_E: begin op_sel = OP_PRE; cmd_bank = sb_q; end
        ST_PRE_B, ST_PRE_F: begin op_sel = OP_PRE; cmd_bank = db_q; end
        ST_ACT_S: begin
          op_sel = OP_ACT; cmd_bank = sb_q; cmd_sub = ss_q; cmd_row = sr_q;
        end
        ST_ACT_D: begin
          op_sel = OP_ACT; cmd_bank = db_q; cmd_sub = ds_q; cmd_row = dr_q;
        end
        ST_XFER: begin
          op_sel = OP_XFER; cmd_bank = sb_q; cmd_peer_bank = db_q; cmd_col = col;
        end
        default: op_sel = OP_NOP;
      endcase
    end
  end

  assign cmd_valid = issue;
  assign cmd_op    = op_sel;
  assign busy      = cmd_state;
  assign done      = (state_q == ST_DONE);

  // Assertions
  a_r9_done_one_cycle : assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_cmd_only_busy : assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);

  a_r9_done_not_busy : assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !cmd_valid);

  a_r2_fast_no_xfer : assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !streaming_q |-> cmd_op != OP_XFER);

  a_r5_xfer_back_to_back : assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == OP_XFER) && (cmd_col != COL_W'(COLS - 1))
    |=> cmd_valid && (cmd_op == OP_XFER));

  a_r8_trivial_no_cmd : assert property (@(posedge clk) disable iff (!rst_n)
    accept && rt_trivial |=> done && !busy);

  a_r10_operands_stable : assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(dr_q) && $stable(sr_q) && $stable(db_q) && $stable(sb_q));

endmodule

// File: tb/sim_bulk_row_copier.sv
`timescale 1ns/1ps
module sim_bulk_row_copier;

  localparam int BW = 2, SW = 2, RW = 4, NC = 8, GW = 4, CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_zero = 1'b0;
  logic [BW-1:0] req_src_bank = '0, req_dst_bank = '0;
  logic [SW-1:0] req_src_sub = '0, req_dst_sub = '0;
  logic [RW-1:0] req_src_row = '0, req_dst_row = '0;
  logic [GW-1:0] cfg_act_act = '0, cfg_act_xfer = '0, cfg_xfer_pre = '0;
  logic          busy, done, cmd_valid;
  logic [1:0]    cmd_op;
  logic [BW-1:0] cmd_bank, cmd_peer_bank;
  logic [SW-1:0] cmd_sub;
  logic [RW-1:0] cmd_row;
  logic [CW-1:0] cmd_col;

  bulk_row_copier #(.BANK_W(BW), .SUB_W(SW), .ROW_W(RW), .COLS(NC), .GAP_W(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_zero(req_zero),
    .req_src_bank(req_src_bank), .req_src_sub(req_src_sub), .req_src_row(req_src_row),
    .req_dst_bank(req_dst_bank), .req_dst_sub(req_dst_sub), .req_dst_row(req_dst_row),
    .cfg_act_act(cfg_act_act), .cfg_act_xfer(cfg_act_xfer), .cfg_xfer_pre(cfg_xfer_pre),
    .busy(busy), .done(done), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_sub(cmd_sub), .cmd_row(cmd_row),
    .cmd_peer_bank(cmd_peer_bank), .cmd_col(cmd_col)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Expected command timetable
  int ex_n;
  int ex_cyc [0:31];
  int ex_op  [0:31];
  int ex_bk  [0:31];
  int ex_sb  [0:31];
  int ex_rw  [0:31];
  int ex_pb  [0:31];
  int ex_cl  [0:31];

  function automatic int g(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  task automatic push(input int c, input int op, input int bk, input int sb,
                      input int rw, input int pb, input int cl);
    ex_cyc[ex_n] = c; ex_op[ex_n] = op; ex_bk[ex_n] = bk; ex_sb[ex_n] = sb;
    ex_rw[ex_n] = rw; ex_pb[ex_n] = pb; ex_cl[ex_n] = cl;
    ex_n++;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at t=%0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // Run one request. zero: clear request. stray: poke req_valid mid-operation (R10).
  task automatic run_op(input bit zero, input int sb, input int ss, input int sr,
                        input int db, input int ds, input int dr,
                        input int aa, input int ax, input int xp,
                        input bit stray, input string tag);
    int esb, ess, esr, last_c, idx;
    bit streaming, trivial, got_done;
    esb = zero ? db : sb;
    ess = zero ? ds : ss;
    esr = zero ? 0 : sr;
    streaming = (esb != db) || (ess != ds);
    trivial = !streaming && (esr == dr);
    ex_n = 0;
    if (trivial) begin
      last_c = 0;
    end else if (!streaming) begin
      push(1, 2, esb, 0, 0, 0, 0);
      push(2, 1, esb, ess, esr, 0, 0);
      push(2 + g(aa), 1, db, ds, dr, 0, 0);
      push(2 + 2*g(aa), 2, esb, 0, 0, 0, 0);
      last_c = 2 + 2*g(aa);
    end else begin
      int l;
      push(1, 2, esb, 0, 0, 0, 0);
      push(2, 2, db, 0, 0, 0, 0);
      push(3, 1, esb, ess, esr, 0, 0);
      push(3 + g(aa), 1, db, ds, dr, 0, 0);
      for (int c = 0; c < NC; c++)
        push(3 + g(aa) + g(ax) + c, 3, esb, 0, 0, db, c);
      l = 3 + g(aa) + g(ax) + NC - 1;
      push(l + g(xp), 2, esb, 0, 0, 0, 0);
      push(l + g(xp) + 1, 2, db, 0, 0, 0, 0);
      last_c = l + g(xp) + 1;
    end

    @(negedge clk);
    req_valid = 1'b1; req_zero = zero;
    req_src_bank = BW'(sb); req_src_sub = SW'(ss); req_src_row = RW'(sr);
    req_dst_bank = BW'(db); req_dst_sub = SW'(ds); req_dst_row = RW'(dr);
    cfg_act_act = GW'(aa); cfg_act_xfer = GW'(ax); cfg_xfer_pre = GW'(xp);

    idx = 0;
    got_done = 0;
    for (int c = 1; c <= 120 && !got_done; c++) begin
      bit exp_v;
      @(negedge clk);
      if (c == 1) req_valid = 1'b0;
      exp_v = (idx < ex_n) && (ex_cyc[idx] == c);
      chk(cmd_valid == exp_v, {tag, " cmd_valid timing"}, int'(cmd_valid), int'(exp_v));
      if (cmd_valid && exp_v) begin
        chk(int'(cmd_op) == ex_op[idx], {tag, " op"}, int'(cmd_op), ex_op[idx]);
        chk(int'(cmd_bank) == ex_bk[idx], {tag, " bank"}, int'(cmd_bank), ex_bk[idx]);
        chk(int'(cmd_sub) == ex_sb[idx], {tag, " sub"}, int'(cmd_sub), ex_sb[idx]);
        chk(int'(cmd_row) == ex_rw[idx], {tag, " row"}, int'(cmd_row), ex_rw[idx]);
        chk(int'(cmd_peer_bank) == ex_pb[idx], {tag, " peer"}, int'(cmd_peer_bank), ex_pb[idx]);
        chk(int'(cmd_col) == ex_cl[idx], {tag, " col"}, int'(cmd_col), ex_cl[idx]);
      end
      if (exp_v) idx++;
      chk(busy == (c <= last_c), "R9 busy", int'(busy), int'(c <= last_c));
      chk(done == (c == last_c + 1), "R9 done", int'(done), int'(c == last_c + 1));
      if (done) got_done = 1;
      // R10: a request while busy must not disturb the stream
      if (stray && c == 2) begin
        req_valid = 1'b1; req_zero = 1'b0;
        req_src_bank = BW'(db); req_dst_bank = BW'(sb); req_dst_row = RW'(dr ^ 5);
      end
      if (stray && c == 4) req_valid = 1'b0;
    end
    chk(got_done, {tag, " completion"}, int'(got_done), 1);
    chk(idx == ex_n, {tag, " command count"}, idx, ex_n);
    // Nothing follows completion (R10: no second operation from stray request)
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(!cmd_valid && !busy && !done, {tag, " quiet after done"},
          int'(cmd_valid | busy | done), 0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(!busy, "R1 busy after reset", int'(busy), 0);
    chk(!done, "R1 done after reset", int'(done), 0);
    chk(!cmd_valid, "R1 cmd_valid after reset", int'(cmd_valid), 0);

    // R2, R3: fast path over all act-act gaps and several row pairs
    for (int aa = 0; aa < 4; aa++)
      for (int b = 0; b < 4; b++)
        run_op(0, b, b % 4, 3, b, b % 4, 9 + aa, aa, 0, 0, 0, "R2 R3 fast");

    // R4, R5, R6: streaming path over a gap sweep, differing bank
    for (int aa = 0; aa < 3; aa++)
      for (int ax = 0; ax < 3; ax++)
        for (int xp = 0; xp < 3; xp++)
          run_op(0, 1, 2, 5, 2, 0, 7, aa * 2, ax + ax / 2, xp * 3, 0, "R4 R5 R6 streaming");
    // same bank, other subarray also streams (R4)
    run_op(0, 3, 1, 4, 3, 2, 4, 1, 2, 1, 0, "R4 same bank other sub");

    // R7: clear requests use the zero row of the destination subarray
    run_op(1, 0, 0, 0, 2, 3, 6, 2, 0, 0, 0, "R7 clear");
    run_op(1, 3, 1, 12, 1, 1, 15, 0, 5, 5, 0, "R7 clear ignores source");

    // R8: source equals destination, and clear of the zero row itself
    run_op(0, 2, 1, 6, 2, 1, 6, 3, 3, 3, 0, "R8 same row");
    run_op(1, 0, 0, 9, 3, 2, 0, 1, 1, 1, 0, "R8 clear of zero row");

    // R10: requests during an operation are ignored
    run_op(0, 1, 1, 2, 1, 1, 3, 3, 0, 0, 1, "R10 fast stray");
    run_op(0, 0, 0, 2, 3, 1, 3, 2, 2, 2, 1, "R10 streaming stray");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule